// File: doc/BRIEF.md
# Clock Divider Bank with Synchronized Ratio Update

This block generates three system clocks from a selectable source through programmable integer dividers. The source is either a multiplied PLL clock or the reference clock. Two more clocks come straight from the reference: a bypass clock and an observation clock, each with its own divider. A gated copy of the reference is also provided as an auxiliary clock. Every clock is represented as a one-cycle tick strobe in the block's single clock domain. The PLL and reference edges arrive as tick inputs.

Software writes new system divider ratios into staging registers. These ratios do nothing until a go command is issued. The go command waits a fixed number of PLL ticks. It then loads all staged ratios together and restarts the flagged dividers on the same edge. Change bits record which dividers were rewritten since the last go, and a busy flag reports when an update is pending. A multiplier field is presented to the PLL model as its multiply factor.

The register port is a plain write strobe with a combinational read. Addresses and fields are listed in the requirements.

Top module: `clkdiv_bank`

## Requirements
- R1: After reset the three system divider registers (addresses 2, 3, 4; ratio in bits [4:0], enable in bit 15) read 0x8000, 0x8002 and 0x8005. Control (address 0; bit 0 PLL enable, bit 1 source lock) reads 0x0002. Multiplier (address 1) reads 0x0010. Alignment mask (address 9) reads 0x0007. Clock enables (address 11) read 0x0003. Busy (address 8 bit 0) and change bits (address 10) read 0. System status (address 13) reads 0x0007.
- R2: A system divider with ratio field N issues one tick every N+1 source ticks.
- R3: The source is the PLL tick only when control bit 1 is 0 and bit 0 is 1. In every other case the reference tick is the source.
- R4: A write to a system divider register stores its ratio without affecting the running divider. The same write sets that divider's change bit (address 10, bit i for divider i).
- R5: Writing 1 to bit 0 of the command register (address 7) while idle sets busy from the next cycle. On the GO_LAT-th following PLL tick, the staged ratios are loaded, the change bits clear and busy returns to 0. Writing 0 has no effect on busy, the change bits or any divider.
- R6: When a go completes, every divider whose change bit or alignment bit is set restarts its count on the same edge, so related ratios tick in phase afterwards.
- R7: Bit 15 of a system divider register gates its tick immediately. Address 13 bit i follows that enable.
- R8: The multiplier output equals the 5-bit multiplier field plus one.
- R9: The bypass divider (address 5) and the observation divider (address 6) divide the reference tick by ratio field plus one. Each has an enable in bit 15, and a new ratio takes effect without a go.
- R10: Address 11 bit 0 gates the auxiliary clock, which is the reference tick. Bit 1 gates the observation clock. Address 12 reports {bypass on, observation on, auxiliary on} in bits [2:0].
- R11: A divider write in the same cycle a go completes leaves the previously staged ratio as the one applied. The new ratio stays staged and its change bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refTick | input | 1 | Reference clock edge strobe |
| pllTick | input | 1 | PLL output edge strobe |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Read data for regAddr |
| sysTick | output | 3 | System clock tick strobes |
| bpTick | output | 1 | Bypass clock tick |
| obsTick | output | 1 | Observation clock tick |
| auxTick | output | 1 | Auxiliary clock tick |
| pllMult | output | MULT_W+1 | Multiply factor for the PLL |

## Verification
A software write to a divider register can land in the same cycle that a pending go completes. In that cycle, the change-bit clear and the change-bit set compete, and so do the ratio load and the ratio write. The bench reaches that exact cycle by counting PLL ticks from the go write and placing a second ratio write on the completing edge. It then judges the result in three ways: the change bit must still read 1, the measured period must match the ratio staged before the go, and a further go must bring in the newer ratio.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int unsigned SYS_N  = 3;
  localparam int unsigned ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL    = 4'd0,
    A_MULT    = 4'd1,
    A_DIV0    = 4'd2,
    A_DIV1    = 4'd3,
    A_DIV2    = 4'd4,
    A_BPDIV   = 4'd5,
    A_OSCDIV  = 4'd6,
    A_CMD     = 4'd7,
    A_STAT    = 4'd8,
    A_ALIGN   = 4'd9,
    A_CHG     = 4'd10,
    A_CKEN    = 4'd11,
    A_CKSTAT  = 4'd12,
    A_SYSSTAT = 4'd13
  } regAddr_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic             apply;
    logic [SYS_N-1:0] restart;
  } divStrobe_t;

  function automatic logic [ADDR_W-1:0] divAddr(input int i);
    return ADDR_W'(int'(A_DIV0) + i);
  endfunction

  function automatic int sysResetRatio(input int i);
    case (i)
      0:       return 0;
      1:       return 2;
      default: return 5;
    endcase
  endfunction
endpackage

// File: rtl/clkdiv_cnt.sv
module clkdiv_cnt #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         srcTick,
  input  logic         restart,
  input  logic [W-1:0] ratio,
  output logic         tickOut
);
  logic [W-1:0] cnt;
  logic         hit;

  assign hit     = (cnt >= ratio);
  assign tickOut = srcTick & hit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cnt <= '0;
    else if (restart) cnt <= '0;
    else if (srcTick) cnt <= hit ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_pkg::*;
#(
  parameter int unsigned RATIO_W = 5,
  parameter int unsigned MULT_W  = 5,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned GO_LAT  = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            pllTick,
  input  logic                            regWr,
  input  logic [ADDR_W-1:0]               regAddr,
  input  logic [DATA_W-1:0]               regWdata,
  output logic [DATA_W-1:0]               regRdata,
  output logic [SYS_N-1:0][RATIO_W-1:0]   stagedRatio,
  output logic [SYS_N-1:0]                sysEn,
  output logic [RATIO_W-1:0]              bpRatio,
  output logic                            bpEn,
  output logic [RATIO_W-1:0]              oscRatio,
  output logic                            oscEn,
  output logic                            auxEn,
  output logic                            obsEn,
  output logic                            useSrcPll,
  output logic                            busy,
  output logic [MULT_W:0]                 pllMult,
  output divStrobe_t                      strobe
);
  localparam int unsigned EN_BIT = DATA_W - 1;
  localparam int unsigned GO_W   = $clog2(GO_LAT + 1);
  localparam logic [MULT_W-1:0] MULT_RST = MULT_W'(16);

  logic               pllEn, enSrc, goBit;
  logic [MULT_W-1:0]  multF;
  logic [SYS_N-1:0]   alignMask, chg, divWr;
  logic [GO_W-1:0]    goCnt;
  logic               goStart, goDone;

  always_comb begin
    for (int i = 0; i < SYS_N; i++) divWr[i] = regWr && (regAddr == divAddr(i));
  end

  assign goStart   = regWr && (regAddr == A_CMD) && regWdata[0] && !busy;
  assign goDone    = busy && pllTick && (goCnt == GO_W'(GO_LAT - 1));
  assign useSrcPll = !enSrc && pllEn;
  assign pllMult   = {1'b0, multF} + 1'b1;

  assign strobe.apply   = goDone;
  assign strobe.restart = alignMask | chg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pllEn     <= 1'b0;
      enSrc     <= 1'b1;
      multF     <= MULT_RST;
      bpRatio   <= '0;
      bpEn      <= 1'b1;
      oscRatio  <= '0;
      oscEn     <= 1'b1;
      auxEn     <= 1'b1;
      obsEn     <= 1'b1;
      alignMask <= '1;
      goBit     <= 1'b0;
    end else if (regWr) begin
      case (regAddr)
        A_CTRL:   begin pllEn <= regWdata[0]; enSrc <= regWdata[1]; end
        A_MULT:   multF <= regWdata[MULT_W-1:0];
        A_BPDIV:  begin bpRatio <= regWdata[RATIO_W-1:0]; bpEn <= regWdata[EN_BIT]; end
        A_OSCDIV: begin oscRatio <= regWdata[RATIO_W-1:0]; oscEn <= regWdata[EN_BIT]; end
        A_CKEN:   begin auxEn <= regWdata[0]; obsEn <= regWdata[1]; end
        A_ALIGN:  alignMask <= regWdata[SYS_N-1:0];
        A_CMD:    goBit <= regWdata[0];
        default:  ;
      endcase
    end
  end

  // Staged ratios, enables and change tracking
  generate
    for (genvar g = 0; g < SYS_N; g++) begin : gStage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stagedRatio[g] <= RATIO_W'(sysResetRatio(g));
          sysEn[g]       <= 1'b1;
          chg[g]         <= 1'b0;
        end else begin
          if (divWr[g]) begin
            stagedRatio[g] <= regWdata[RATIO_W-1:0];
            sysEn[g]       <= regWdata[EN_BIT];
          end
          chg[g] <= (chg[g] & ~goDone) | divWr[g];
        end
      end
    end
  endgenerate

  // Go sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy  <= 1'b0;
      goCnt <= '0;
    end else if (goStart) begin
      busy  <= 1'b1;
      goCnt <= '0;
    end else if (busy && pllTick) begin
      if (goDone) busy <= 1'b0;
      else        goCnt <= goCnt + 1'b1;
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      A_CTRL:    regRdata[1:0] = {enSrc, pllEn};
      A_MULT:    regRdata[MULT_W-1:0] = multF;
      A_BPDIV:   begin regRdata[RATIO_W-1:0] = bpRatio; regRdata[EN_BIT] = bpEn; end
      A_OSCDIV:  begin regRdata[RATIO_W-1:0] = oscRatio; regRdata[EN_BIT] = oscEn; end
      A_CMD:     regRdata[0] = goBit;
      A_STAT:    regRdata[0] = busy;
      A_ALIGN:   regRdata[SYS_N-1:0] = alignMask;
      A_CHG:     regRdata[SYS_N-1:0] = chg;
      A_CKEN:    regRdata[1:0] = {obsEn, auxEn};
      A_CKSTAT:  regRdata[2:0] = {bpEn, obsEn & oscEn, auxEn};
      A_SYSSTAT: regRdata[SYS_N-1:0] = sysEn;
      default:   ;
    endcase
    for (int i = 0; i < SYS_N; i++) begin
      if (regAddr == divAddr(i)) begin
        regRdata[RATIO_W-1:0] = stagedRatio[i];
        regRdata[EN_BIT]      = sysEn[i];
      end
    end
  end
endmodule

// File: rtl/clkdiv_path.sv
module clkdiv_path
  import clkdiv_pkg::*;
#(
  parameter int unsigned RATIO_W = 5
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          refTick,
  input  logic                          pllTick,
  input  logic                          useSrcPll,
  input  logic [SYS_N-1:0][RATIO_W-1:0] stagedRatio,
  input  logic [SYS_N-1:0]              sysEn,
  input  divStrobe_t                    strobe,
  input  logic [RATIO_W-1:0]            bpRatio,
  input  logic                          bpEn,
  input  logic [RATIO_W-1:0]            oscRatio,
  input  logic                          oscEn,
  input  logic                          auxEn,
  input  logic                          obsEn,
  output logic [SYS_N-1:0]              sysTick,
  output logic                          bpTick,
  output logic                          obsTick,
  output logic                          auxTick
);
  logic                          srcTick, bpRaw, obsRaw;
  logic [SYS_N-1:0][RATIO_W-1:0] activeRatio;
  logic [SYS_N-1:0]              sysRaw;

  assign srcTick = useSrcPll ? pllTick : refTick;

  generate
    for (genvar g = 0; g < SYS_N; g++) begin : gSys
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             activeRatio[g] <= RATIO_W'(sysResetRatio(g));
        else if (strobe.apply) activeRatio[g] <= stagedRatio[g];
      end

      clkdiv_cnt #(.W(RATIO_W)) uDiv (
        .clk     (clk),
        .rstN    (rstN),
        .srcTick (srcTick),
        .restart (strobe.apply & strobe.restart[g]),
        .ratio   (activeRatio[g]),
        .tickOut (sysRaw[g])
      );
      assign sysTick[g] = sysRaw[g] & sysEn[g];
    end
  endgenerate

  clkdiv_cnt #(.W(RATIO_W)) uBp (
    .clk (clk), .rstN (rstN), .srcTick (refTick), .restart (1'b0),
    .ratio (bpRatio), .tickOut (bpRaw)
  );

  clkdiv_cnt #(.W(RATIO_W)) uObs (
    .clk (clk), .rstN (rstN), .srcTick (refTick), .restart (1'b0),
    .ratio (oscRatio), .tickOut (obsRaw)
  );

  assign bpTick  = bpRaw & bpEn;
  assign obsTick = obsRaw & oscEn & obsEn;
  assign auxTick = refTick & auxEn;
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
  import clkdiv_pkg::*;
#(
  parameter int unsigned RATIO_W = 5,
  parameter int unsigned MULT_W  = 5,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned GO_LAT  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refTick,
  input  logic              pllTick,
  input  logic              regWr,
  input  logic [3:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic [2:0]        sysTick,
  output logic              bpTick,
  output logic              obsTick,
  output logic              auxTick,
  output logic [MULT_W:0]   pllMult
);
  logic [SYS_N-1:0][RATIO_W-1:0] stagedRatio;
  logic [SYS_N-1:0]              sysEn;
  logic [RATIO_W-1:0]            bpRatio, oscRatio;
  logic                          bpEn, oscEn, auxEn, obsEn, useSrcPll, busy;
  divStrobe_t                    strobe;

  clkdiv_ctrl #(
    .RATIO_W (RATIO_W), .MULT_W (MULT_W), .DATA_W (DATA_W), .GO_LAT (GO_LAT)
  ) uCtrl (
    .clk (clk), .rstN (rstN), .pllTick (pllTick),
    .regWr (regWr), .regAddr (regAddr), .regWdata (regWdata), .regRdata (regRdata),
    .stagedRatio (stagedRatio), .sysEn (sysEn),
    .bpRatio (bpRatio), .bpEn (bpEn), .oscRatio (oscRatio), .oscEn (oscEn),
    .auxEn (auxEn), .obsEn (obsEn), .useSrcPll (useSrcPll), .busy (busy),
    .pllMult (pllMult), .strobe (strobe)
  );

  clkdiv_path #(.RATIO_W (RATIO_W)) uPath (
    .clk (clk), .rstN (rstN), .refTick (refTick), .pllTick (pllTick),
    .useSrcPll (useSrcPll), .stagedRatio (stagedRatio), .sysEn (sysEn),
    .strobe (strobe), .bpRatio (bpRatio), .bpEn (bpEn),
    .oscRatio (oscRatio), .oscEn (oscEn), .auxEn (auxEn), .obsEn (obsEn),
    .sysTick (sysTick), .bpTick (bpTick), .obsTick (obsTick), .auxTick (auxTick)
  );
endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk
  import clkdiv_pkg::*;
#(
  parameter int unsigned MULT_W = 5,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              refTick,
  input logic              pllTick,
  input logic              regWr,
  input logic [3:0]        regAddr,
  input logic [DATA_W-1:0] regWdata,
  input logic              busy,
  input logic [2:0]        sysTick,
  input logic [2:0]        sysEn,
  input logic              useSrcPll,
  input logic              auxTick,
  input logic [MULT_W:0]   pllMult
);
  // R5
  go_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(regWr && (regAddr == A_CMD) && regWdata[0]));

  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !pllTick) |=> busy);

  // R7
  tick_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|sysTick) |-> ((sysTick & ~sysEn) == 3'b000));

  // R3
  bypass_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!useSrcPll && (|sysTick)) |-> refTick);

  // R10
  aux_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    auxTick |-> refTick);

  // R8
  mult_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regWr && (regAddr == A_MULT)) |=> $stable(pllMult));
endmodule

bind clkdiv_bank clkdiv_bank_chk #(.MULT_W (MULT_W), .DATA_W (DATA_W)) uChk (
  .clk (clk), .rstN (rstN), .refTick (refTick), .pllTick (pllTick),
  .regWr (regWr), .regAddr (regAddr), .regWdata (regWdata), .busy (busy),
  .sysTick (sysTick), .sysEn (sysEn), .useSrcPll (useSrcPll),
  .auxTick (auxTick), .pllMult (pllMult)
);

// File: tb/sim_clkdiv_bank.sv
`timescale 1ns/1ps
module sim_clkdiv_bank;
  import clkdiv_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  refCnt;
  logic        refTick;
  logic        pllTick = 1'b1;
  logic        regWr = 1'b0;
  logic [3:0]  regAddr = 4'd0;
  logic [15:0] regWdata = 16'd0;
  logic [15:0] regRdata;
  logic [2:0]  sysTick;
  logic        bpTick, obsTick, auxTick;
  logic [5:0]  pllMult;

  int chkCnt = 0;
  int failCnt = 0;

  always #2 clk = ~clk;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) refCnt <= 2'd0;
    else       refCnt <= (refCnt == 2'd2) ? 2'd0 : refCnt + 2'd1;
  end
  assign refTick = (refCnt == 2'd2);

  clkdiv_bank u0 (
    .clk (clk), .rstN (rstN), .refTick (refTick), .pllTick (pllTick),
    .regWr (regWr), .regAddr (regAddr), .regWdata (regWdata), .regRdata (regRdata),
    .sysTick (sysTick), .bpTick (bpTick), .obsTick (obsTick), .auxTick (auxTick),
    .pllMult (pllMult)
  );

  task automatic check(input string req, input int got, input int exp);
    chkCnt++;
    if (got !== exp) begin
      failCnt++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    @(negedge clk); regAddr = a; #1; v = int'(regRdata);
  endtask

  task automatic waitIdle();
    int v;
    for (int k = 0; k < 100; k++) begin
      rd(A_STAT, v);
      if (v == 0) break;
    end
  endtask

  task automatic doGo();
    wr(A_CMD, 16'h0001);
    waitIdle();
  endtask

  function automatic logic tickOf(input int idx);
    case (idx)
      0, 1, 2: return sysTick[idx];
      3:       return bpTick;
      4:       return obsTick;
      default: return auxTick;
    endcase
  endfunction

  task automatic measure(input int idx, output int per);
    int n;
    per = -1;
    n = 0;
    do begin @(negedge clk); n++; end while (!tickOf(idx) && n < 300);
    if (!tickOf(idx)) return;
    n = 0;
    do begin @(negedge clk); n++; end while (!tickOf(idx) && n < 300);
    if (tickOf(idx)) per = n;
  endtask

  task automatic countTicks(input int idx, input int cycles, output int c);
    c = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (tickOf(idx)) c++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chkCnt++; failCnt++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", chkCnt - failCnt, chkCnt);
    $finish;
  end

  initial begin
    int v, p, n2, bad;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(A_DIV0, v);    check("R1 div0", v, 16'h8000);
    rd(A_DIV1, v);    check("R1 div1", v, 16'h8002);
    rd(A_DIV2, v);    check("R1 div2", v, 16'h8005);
    rd(A_CTRL, v);    check("R1 ctrl", v, 2);
    rd(A_MULT, v);    check("R1 mult", v, 16'h10);
    rd(A_ALIGN, v);   check("R1 align", v, 7);
    rd(A_CKEN, v);    check("R1 cken", v, 3);
    rd(A_STAT, v);    check("R1 busy", v, 0);
    rd(A_CHG, v);     check("R1 chg", v, 0);
    rd(A_SYSSTAT, v); check("R1 sysstat", v, 7);
    check("R8 reset multiply", int'(pllMult), 17);

    // R3 reset state is bypass: reference period 3
    measure(0, p); check("R3 bypass div0", p, 3);
    measure(1, p); check("R2 bypass div1", p, 9);
    measure(2, p); check("R2 bypass div2", p, 18);

    // R3 PLL selected
    wr(A_CTRL, 16'h0001);
    measure(0, p); check("R3 pll div0", p, 1);
    measure(1, p); check("R2 pll div1", p, 3);
    measure(2, p); check("R2 pll div2", p, 6);
    // R3 source lock set: enable ignored
    wr(A_CTRL, 16'h0003);
    measure(0, p); check("R3 lock bypass", p, 3);
    wr(A_CTRL, 16'h0001);

    // R4 staging
    wr(A_DIV0, 16'h8003);
    rd(A_CHG, v);  check("R4 chg set", v, 1);
    measure(0, p); check("R4 staged no effect", p, 1);
    // R5 write 0 has no effect
    wr(A_CMD, 16'h0000);
    rd(A_STAT, v); check("R5 zero no busy", v, 0);
    rd(A_CHG, v);  check("R5 zero keeps chg", v, 1);
    measure(0, p); check("R5 zero no apply", p, 1);
    // R5 go
    wr(A_CMD, 16'h0001);
    rd(A_STAT, v); check("R5 busy set", v, 1);
    waitIdle();
    rd(A_CHG, v);  check("R5 chg cleared", v, 0);
    measure(0, p); check("R5 applied", p, 4);

    // R6 alignment after go
    wr(A_DIV0, 16'h8001);
    wr(A_DIV2, 16'h8003);
    doGo();
    n2 = 0; bad = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (sysTick[2]) begin n2++; if (!sysTick[0]) bad++; end
    end
    check("R6 misaligned ticks", bad, 0);
    check("R6 tick count", n2, 10);

    // R2 sweep of ratios on all dividers
    for (int r = 0; r < 8; r++) begin
      for (int i = 0; i < 3; i++) wr(divAddr(i), 16'h8000 | 16'(r));
      doGo();
      for (int i = 0; i < 3; i++) begin
        measure(i, p); check("R2 sweep", p, r + 1);
      end
    end

    // R7 enable gating
    wr(A_DIV1, 16'h0001);
    rd(A_SYSSTAT, v); check("R7 sysstat", v, 5);
    countTicks(1, 30, v); check("R7 disabled ticks", v, 0);
    wr(A_DIV1, 16'h8001);
    countTicks(1, 32, v); check("R7 reenabled ticks", v, 4);

    // R8 multiplier
    wr(A_MULT, 16'h0004);
    check("R8 multiply", int'(pllMult), 5);

    // R9 reference dividers, immediate
    measure(3, p); check("R9 bp default", p, 3);
    measure(4, p); check("R9 obs default", p, 3);
    wr(A_BPDIV, 16'h8002);
    measure(3, p); check("R9 bp ratio", p, 9);
    wr(A_OSCDIV, 16'h8001);
    measure(4, p); check("R9 obs ratio", p, 6);
    wr(A_BPDIV, 16'h0002);
    countTicks(3, 30, v); check("R9 bp disabled", v, 0);

    // R10 clock enables
    measure(5, p); check("R10 aux period", p, 3);
    wr(A_CKEN, 16'h0002);
    countTicks(5, 30, v); check("R10 aux off", v, 0);
    rd(A_CKSTAT, v); check("R10 ckstat aux off", v, 2);
    wr(A_CKEN, 16'h0001);
    countTicks(4, 30, v); check("R10 obs off", v, 0);
    rd(A_CKSTAT, v); check("R10 ckstat obs off", v, 1);

    // R11 write lands on the go completion edge
    wr(A_DIV0, 16'h8002);
    @(negedge clk); regWr = 1'b1; regAddr = A_CMD; regWdata = 16'h0001;
    @(negedge clk); regWr = 1'b0;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk); regWr = 1'b1; regAddr = A_DIV0; regWdata = 16'h8004;
    @(negedge clk); regWr = 1'b0;
    rd(A_STAT, v); check("R11 idle", v, 0);
    rd(A_CHG, v);  check("R11 chg kept", v & 1, 1);
    measure(0, p); check("R11 old staged applied", p, 3);
    doGo();
    measure(0, p); check("R11 new ratio later", p, 5);

    $display("%0d/%0d checks passed", chkCnt - failCnt, chkCnt);
    $finish;
  end
endmodule